// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block keeps the tap positions of four digitally controlled resistor ladders. Every ladder has an 8-bit wiper register and a set of four 8-bit data registers of its own. A serial front end decodes host transactions and hands the bank one command strobe per cycle. A command can load a wiper directly, fill a data register, copy one of the data registers into the wiper, or read back any register.

Each ladder has 255 series segments, so it has 256 taps. For every ladder the bank expands the wiper register into a 256-bit switch-select vector in which exactly one bit is set. Bit `a*256 + v` of `tap_sel` closes tap `v` of ladder `a`. The vector is decoded straight from the wiper register, so it changes in the cycle the wiper register changes and never passes through a state with zero or two taps.

A small sequencer handles read replies. It has two states. In `ST_IDLE` no reply is on the bus. A read command taken in any state moves it to `ST_REPLY` (transition "read accepted"). There it presents the register value with `rd_valid` high for one cycle. It then returns to `ST_IDLE` (transition "reply done"), unless another read arrives, in which case it stays in `ST_REPLY`.

Top module: `wiper_bank`

## Requirements
- R1: After reset every wiper register and every data register holds 0, tap 0 is selected in all four ladders, and `rd_valid` is low.
- R2: A command with `cmd_op`=1 loads `cmd_data` into the wiper register of ladder `cmd_arr`. At the clock edge that accepts it, that ladder's tap select moves to tap `cmd_data`.
- R3: A command with `cmd_op`=2 and `fe_busy` low stores `cmd_data` into data register `cmd_reg` of ladder `cmd_arr`.
- R4: A command with `cmd_op`=2 while `fe_busy` is high leaves every data register unchanged.
- R5: A command with `cmd_op`=3 copies data register `cmd_reg` of ladder `cmd_arr` into that ladder's wiper register, and the tap select follows at the same edge.
- R6: A command with `cmd_op`=4 reads the wiper register of ladder `cmd_arr`. After the accepting edge, `rd_valid` is high and `rd_data` holds the value for one cycle.
- R7: A command with `cmd_op`=5 reads data register `cmd_reg` of ladder `cmd_arr`, with the same reply timing as R6.
- R8: In each ladder exactly one of the 256 tap-select bits is set at all times.
- R9: A command changes only the ladder named by `cmd_arr`. All other ladders keep their registers and tap selects.
- R10: A cycle with `cmd_valid` low, or with `cmd_op` equal to 0, 6 or 7, changes no register and produces no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Operation: 1 wiper write, 2 data write, 3 transfer, 4 wiper read, 5 data read |
| cmd_arr | input | 2 | Target ladder |
| cmd_reg | input | 2 | Target data register |
| cmd_data | input | 8 | Write value |
| fe_busy | input | 1 | Front end busy; blocks data-register writes |
| rd_valid | output | 1 | Read reply valid |
| rd_data | output | 8 | Read reply value |
| tap_sel | output | 1024 | One-hot tap selects, 256 per ladder |

## Verification
Every result is due at the first clock edge after the command is presented. A wiper write or a transfer shows up on `tap_sel` through the decoder with no extra register. A read reply appears on `rd_data` and `rd_valid` through the single sequencer register. The bench changes inputs on falling edges and holds a command across exactly one rising edge. It then compares outputs at the next falling edge, which is the first point where a result is due and the last point before it could be overwritten. To check the ignored-write cases, the bench reads the affected registers back through the normal read path.

// File: rtl/wb_pkg.sv
package wb_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_WR_WIPER = 3'd1,
        OP_WR_DATA  = 3'd2,
        OP_XFER     = 3'd3,
        OP_RD_WIPER = 3'd4,
        OP_RD_DATA  = 3'd5
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/tap_decoder.sv
module tap_decoder #(
    parameter int WBITS = 8,
    localparam int TAPS = 1 << WBITS
) (
    input  logic [WBITS-1:0] code,
    output logic [TAPS-1:0]  onehot
);
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign onehot[t] = (code == WBITS'(t));
    end
endmodule

// File: rtl/wiper_slot.sv
module wiper_slot
    import wb_pkg::*;
#(
    parameter int WBITS  = 8,
    parameter int N_DREG = 4,
    localparam int RW = $clog2(N_DREG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hit,
    input  op_e                          op,
    input  logic [RW-1:0]                reg_idx,
    input  logic [WBITS-1:0]             wdata,
    input  logic                         busy,
    output logic [WBITS-1:0]             wiper_q,
    output logic [N_DREG-1:0][WBITS-1:0] dreg_q
);
    logic [WBITS-1:0] sel_dreg;
    assign sel_dreg = dreg_q[reg_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q <= '0;
        end else if (hit) begin
            unique case (op)
                OP_WR_WIPER: wiper_q <= wdata;
                OP_XFER:     wiper_q <= sel_dreg;
                default:     wiper_q <= wiper_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dreg_q <= '0;
        end else if (hit && op == OP_WR_DATA && !busy) begin
            dreg_q[reg_idx] <= wdata;
        end
    end

    a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_WR_WIPER) |=> wiper_q == $past(wdata));
    a_r5_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_XFER) |=> wiper_q == $past(sel_dreg));
    a_r4_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_WR_DATA && busy) |=> $stable(dreg_q));
    a_r9_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(wiper_q) && $stable(dreg_q)));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wb_pkg::*;
#(
    parameter int N_ARR  = 4,
    parameter int WBITS  = 8,
    parameter int N_DREG = 4,
    localparam int TAPS = 1 << WBITS,
    localparam int AW   = $clog2(N_ARR),
    localparam int RW   = $clog2(N_DREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [AW-1:0]         cmd_arr,
    input  logic [RW-1:0]         cmd_reg,
    input  logic [WBITS-1:0]      cmd_data,
    input  logic                  fe_busy,
    output logic                  rd_valid,
    output logic [WBITS-1:0]      rd_data,
    output logic [N_ARR*TAPS-1:0] tap_sel
);
    op_e op;
    assign op = op_e'(cmd_op);

    logic [N_ARR-1:0][WBITS-1:0]              wipers;
    logic [N_ARR-1:0][N_DREG-1:0][WBITS-1:0]  dregs;

    for (genvar g = 0; g < N_ARR; g++) begin : g_arr
        logic hit;
        assign hit = cmd_valid && (cmd_arr == AW'(g));

        wiper_slot #(.WBITS(WBITS), .N_DREG(N_DREG)) u_slot (
            .clk(clk), .rst_n(rst_n), .hit(hit), .op(op),
            .reg_idx(cmd_reg), .wdata(cmd_data), .busy(fe_busy),
            .wiper_q(wipers[g]), .dreg_q(dregs[g])
        );

        tap_decoder #(.WBITS(WBITS)) u_dec (
            .code(wipers[g]),
            .onehot(tap_sel[g*TAPS +: TAPS])
        );

        a_r8_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(tap_sel[g*TAPS +: TAPS]));
    end

    rsp_state_e state_q, state_d;
    logic       is_read;
    logic [WBITS-1:0] rd_next, rd_q;

    assign is_read = cmd_valid && (op == OP_RD_WIPER || op == OP_RD_DATA);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (is_read) state_d = ST_REPLY;
            ST_REPLY: if (!is_read) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_next = rd_q;
        if (is_read) begin
            if (op == OP_RD_WIPER) rd_next = wipers[cmd_arr];
            else                   rd_next = dregs[cmd_arr][cmd_reg];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            rd_q    <= rd_next;
        end
    end

    always_comb begin
        rd_valid = (state_q == ST_REPLY);
        rd_data  = rd_q;
    end

    a_r6_reply_due: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> rd_valid);
    a_r10_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> !rd_valid);
endmodule

// File: tb/tb_wiper_bank.sv
module tb_wiper_bank;
    localparam int TAPS = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = 3'd0;
    logic [1:0]   cmd_arr = 2'd0;
    logic [1:0]   cmd_reg = 2'd0;
    logic [7:0]   cmd_data = 8'd0;
    logic         fe_busy = 1'b0;
    logic         rd_valid;
    logic [7:0]   rd_data;
    logic [1023:0] tap_sel;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    wiper_bank dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arr(cmd_arr), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
        .fe_busy(fe_busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .tap_sel(tap_sel)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_tap(input string req, input int arr, input int exp);
        logic [TAPS-1:0] slice;
        slice = tap_sel[arr*TAPS +: TAPS];
        total++;
        if (slice != (256'd1 << exp)) begin
            bad++;
            $display("FAIL %s: ladder %0d ones=%0d bit_set=%0d expected tap %0d",
                     req, arr, $countones(slice), slice[exp], exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input int arr, input int rg,
                         input int data, input logic busy);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arr = 2'(arr);
        cmd_reg = 2'(rg); cmd_data = 8'(data); fe_busy = busy;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; fe_busy = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [2:0] op,
                              input int arr, input int rg, input int exp);
        issue(op, arr, rg, 0, 1'b0);
        check({req, " valid"}, int'(rd_valid), 1);
        check({req, " data"}, int'(rd_data), exp);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 4; a++) check_tap("R1 reset tap", a, 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        read_check("R1 dreg", 3'd5, 2, 3, 0);
        read_check("R1 wiper", 3'd4, 3, 0, 0);
    endtask

    task automatic t_direct;
        issue(3'd1, 1, 0, 200, 1'b0);
        check_tap("R2 direct", 1, 200);
        check_tap("R9 other", 0, 0);
        issue(3'd1, 1, 0, 255, 1'b0);
        check_tap("R2 top tap", 1, 255);
        read_check("R6 wiper read", 3'd4, 1, 0, 255);
        @(negedge clk);
        check("R6 one cycle", int'(rd_valid), 0);
        issue(3'd1, 1, 0, 0, 1'b0);
        check_tap("R8 back to 0", 1, 0);
    endtask

    task automatic t_data;
        issue(3'd2, 2, 1, 8'h5A, 1'b0);
        check_tap("R9 no tap move", 2, 0);
        read_check("R3 R7 dreg", 3'd5, 2, 1, 8'h5A);
        issue(3'd2, 2, 1, 8'h11, 1'b1);
        read_check("R4 busy ignored", 3'd5, 2, 1, 8'h5A);
        issue(3'd2, 3, 1, 8'h77, 1'b0);
        read_check("R9 other dreg", 3'd5, 2, 1, 8'h5A);
    endtask

    task automatic t_xfer;
        issue(3'd2, 0, 3, 131, 1'b0);
        issue(3'd3, 0, 3, 9, 1'b0);
        check_tap("R5 transfer", 0, 131);
        check_tap("R9 ladder2 kept", 2, 0);
        read_check("R5 wiper after xfer", 3'd4, 0, 0, 131);
        issue(3'd3, 0, 0, 0, 1'b0);
        check_tap("R5 transfer zero", 0, 0);
    endtask

    task automatic t_ignore;
        issue(3'd1, 3, 0, 40, 1'b0);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd1; cmd_arr = 2'd3; cmd_data = 8'd99;
        @(negedge clk);
        check_tap("R10 valid low", 3, 40);
        check("R10 no reply", int'(rd_valid), 0);
        issue(3'd6, 3, 0, 7, 1'b0);
        check_tap("R10 op6", 3, 40);
        check("R10 op6 reply", int'(rd_valid), 0);
        issue(3'd0, 3, 0, 7, 1'b0);
        check_tap("R10 op0", 3, 40);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_arr = 2'd3;
        @(negedge clk);
        check("R6 first", int'(rd_data), 40);
        cmd_op = 3'd5; cmd_arr = 2'd2; cmd_reg = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        check("R7 second valid", int'(rd_valid), 1);
        check("R7 second data", int'(rd_data), 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_data();
        t_xfer();
        t_ignore();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule